// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow Trap

This block is the integer add/subtract slice of a processor execute stage. It adds or subtracts two 32-bit two's complement operands with a single adder: subtraction feeds the inverted second operand and a carry-in of one. It reports signed overflow. For the trapping opcodes it also raises an exception request. The non-trapping opcodes produce the same bits and never raise one.

The same adder serves signed and unsigned set-less-than. In place of operand B the block can take a 16-bit immediate, sign-extended to 32 bits. The immediate is sign-extended even for the unsigned add form. The inputs are sampled on each rising clock edge. The result, the overflow flag and the trap request come from registers and are valid on the following edge.

Opcode encoding on `opcode` (4 bits): 0 = signed add (trapping), 1 = unsigned add (non-trapping), 2 = signed subtract (trapping), 3 = unsigned subtract (non-trapping), 4 = signed set-less-than, 5 = unsigned set-less-than, 6 to 15 = unused.

Top module: `iu_addsub`

## Requirements
- R1: While `rst` is high at a rising edge, `result`, `ovf_flag` and `ovf_trap` are all zero after that edge.
- R2: For opcodes 0 and 1, `result` is (A + B) mod 2^32. For opcodes 2 and 3, `result` is (A + ~B + 1) mod 2^32. Each result appears one clock edge after its inputs were sampled.
- R3: For opcodes 0 and 1, `ovf_flag` is 1 exactly when A and B have the same sign and the sum's sign differs from it. When A and B differ in sign, `ovf_flag` is always 0.
- R4: For opcodes 2 and 3, `ovf_flag` is 1 exactly when A and B differ in sign and the result's sign differs from A's. When A and B share a sign, `ovf_flag` is always 0.
- R5: `ovf_trap` equals `ovf_flag` for opcodes 0 and 2 only, and is 0 for every other opcode.
- R6: Opcodes 1 and 3 give the same `result` and `ovf_flag` as opcodes 0 and 2, but `ovf_trap` is always 0 for them.
- R7: When `use_imm` is 1, B is `imm` with bit 15 copied into bits 31:16. This applies to every opcode, including opcode 1.
- R8: Opcode 4 writes 1 when A is less than B as signed numbers, and 0 otherwise. The comparison is correct even when A - B overflows.
- R9: Opcode 5 writes 1 when A is less than B as unsigned magnitudes, and 0 otherwise.
- R10: Opcodes 4 to 15 give `ovf_flag` = 0 and `ovf_trap` = 0. Opcodes 6 to 15 give `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B (register form) |
| imm | input | 16 | Immediate, sign-extended when selected |
| use_imm | input | 1 | 1 selects the extended immediate as operand B |
| opcode | input | 4 | Operation code (see encoding above) |
| result | output | 32 | Registered result |
| ovf_flag | output | 1 | Registered raw signed-overflow indicator |
| ovf_trap | output | 1 | Registered overflow exception request |

## Verification
Every result of this block is due one rising edge after its operands and opcode were applied, because all three outputs come from a single register stage. The bench drives each vector on a falling edge and samples the outputs 1 ns after the next rising edge, before the next vector is driven. A sampled value therefore always belongs to exactly one vector. The reset check samples in the same way, one edge after `rst` was held high.

// File: rtl/iu_pkg.sv
package iu_pkg;
  localparam int unsigned OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_ADD  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_ADDU = 4'd1;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_SUBU = 4'd3;
  localparam logic [OPC_W-1:0] OPC_SLT  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_SLTU = 4'd5;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_SUM  = 2'd1,
    SEL_LTS  = 2'd2,
    SEL_LTU  = 2'd3
  } res_sel_e;

  typedef struct packed {
    logic     subtract;
    logic     flag_en;
    logic     trap_en;
    res_sel_e sel;
  } ctrl_t;
endpackage

// File: rtl/iu_imm_ext.sv
module iu_imm_ext #(
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] imm_ext
);
  localparam int unsigned FILL_W = DATA_W - IMM_W;

  generate
    if (FILL_W > 0) begin : g_fill
      assign imm_ext = {{FILL_W{imm[IMM_W-1]}}, imm};
    end else begin : g_pass
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/iu_decode.sv
module iu_decode
  import iu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl
);
  always_comb begin
    ctrl = '{subtract: 1'b0, flag_en: 1'b0, trap_en: 1'b0, sel: SEL_ZERO};
    unique case (opcode)
      OPC_ADD:  ctrl = '{subtract: 1'b0, flag_en: 1'b1, trap_en: 1'b1, sel: SEL_SUM};
      OPC_ADDU: ctrl = '{subtract: 1'b0, flag_en: 1'b1, trap_en: 1'b0, sel: SEL_SUM};
      OPC_SUB:  ctrl = '{subtract: 1'b1, flag_en: 1'b1, trap_en: 1'b1, sel: SEL_SUM};
      OPC_SUBU: ctrl = '{subtract: 1'b1, flag_en: 1'b1, trap_en: 1'b0, sel: SEL_SUM};
      OPC_SLT:  ctrl = '{subtract: 1'b1, flag_en: 1'b0, trap_en: 1'b0, sel: SEL_LTS};
      OPC_SLTU: ctrl = '{subtract: 1'b1, flag_en: 1'b0, trap_en: 1'b0, sel: SEL_LTU};
      default:  ctrl = '{subtract: 1'b0, flag_en: 1'b0, trap_en: 1'b0, sel: SEL_ZERO};
    endcase
  end
endmodule

// File: rtl/iu_adder.sv
module iu_adder #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              subtract,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;

  // Subtraction reuses the adder: invert B and inject a carry-in of one.
  assign b_eff        = subtract ? ~b : b;
  assign {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, subtract};
  // Overflow: both adder inputs share a sign that the sum does not.
  assign ovf          = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/iu_compare.sv
module iu_compare #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] diff,
  input  logic              carry,
  input  logic              ovf,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  // Sign of the true difference survives an overflowing subtraction.
  assign lt_signed   = diff[DATA_W-1] ^ ovf;
  // No carry out of A + ~B + 1 means a borrow occurred: A < B unsigned.
  assign lt_unsigned = ~carry;
endmodule

// File: rtl/iu_addsub.sv
module iu_addsub
  import iu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic [OPC_W-1:0]  opcode,
  output logic [DATA_W-1:0] result,
  output logic              ovf_flag,
  output logic              ovf_trap
);
  localparam int unsigned MSB = DATA_W - 1;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum;
  logic              carry;
  logic              add_ovf;
  logic              lt_s;
  logic              lt_u;
  logic [DATA_W-1:0] res_nxt;
  logic              flag_nxt;

  iu_decode u_dec (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  iu_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
    .imm     (imm),
    .imm_ext (imm_ext)
  );

  assign opnd_b = use_imm ? imm_ext : op_b;

  iu_adder #(.DATA_W(DATA_W)) u_add (
    .a        (op_a),
    .b        (opnd_b),
    .subtract (ctrl.subtract),
    .sum      (sum),
    .carry    (carry),
    .ovf      (add_ovf)
  );

  iu_compare #(.DATA_W(DATA_W)) u_cmp (
    .diff        (sum),
    .carry       (carry),
    .ovf         (add_ovf),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  always_comb begin
    unique case (ctrl.sel)
      SEL_SUM: res_nxt = sum;
      SEL_LTS: res_nxt = {{(DATA_W-1){1'b0}}, lt_s};
      SEL_LTU: res_nxt = {{(DATA_W-1){1'b0}}, lt_u};
      default: res_nxt = '0;
    endcase
  end

  assign flag_nxt = add_ovf & ctrl.flag_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      ovf_flag <= 1'b0;
      ovf_trap <= 1'b0;
    end else begin
      result   <= res_nxt;
      ovf_flag <= flag_nxt;
      ovf_trap <= flag_nxt & ctrl.trap_en;
    end
  end

  // R1: reset clears every output
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !ovf_flag && !ovf_trap));

  // R5: a trap request never appears without the raw flag
  p_trap_needs_flag_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> ovf_flag);

  // R6: unsigned add/sub never request an exception
  p_unsigned_no_trap_r6: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_ADDU || opcode == OPC_SUBU) |=> !ovf_trap);

  // R3: mixed-sign addition never overflows
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    ((opcode == OPC_ADD || opcode == OPC_ADDU) && (op_a[MSB] != opnd_b[MSB]))
      |=> !ovf_flag);

  // R4: same-sign subtraction never overflows
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    ((opcode == OPC_SUB || opcode == OPC_SUBU) && (op_a[MSB] == opnd_b[MSB]))
      |=> !ovf_flag);

  // R8/R9: set-less-than writes only 0 or 1; R10: no flags for it
  p_slt_boolean_r8: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_SLT || opcode == OPC_SLTU)
      |=> (result[MSB:1] == '0 && !ovf_flag && !ovf_trap));

  // R10: unused opcodes give zero outputs
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (opcode > OPC_SLTU) |=> (result == '0 && !ovf_flag && !ovf_trap));
endmodule

// File: tb/iu_addsub_tb.sv
module iu_addsub_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [15:0] imm = '0;
  logic        use_imm = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] result;
  logic        ovf_flag;
  logic        ovf_trap;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  iu_addsub u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .imm(imm),
    .use_imm(use_imm), .opcode(opcode), .result(result),
    .ovf_flag(ovf_flag), .ovf_trap(ovf_trap)
  );

  function automatic logic [31:0] eff_b(logic [31:0] b, logic [15:0] i, logic u);
    return u ? {{16{i[15]}}, i} : b;  // R7
  endfunction

  function automatic logic [31:0] exp_res(logic [31:0] a, logic [31:0] b, logic [3:0] op);
    case (op)
      4'd0, 4'd1: return a + b;
      4'd2, 4'd3: return a - b;
      4'd4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd5: return (a < b) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_ovf(logic [31:0] a, logic [31:0] b, logic [3:0] op);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint r;
    if (op == 4'd0 || op == 4'd1) r = sa + sb;
    else if (op == 4'd2 || op == 4'd3) r = sa - sb;
    else return 1'b0;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  function automatic string tag(logic [3:0] op, logic u);
    if (u && op <= 4'd1) return "R7";
    case (op)
      4'd0: return "R3";
      4'd1: return "R6";
      4'd2: return "R4";
      4'd3: return "R6";
      4'd4: return "R8";
      4'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [15:0] i,
                       logic u, logic [3:0] op);
    logic [31:0] bb, er;
    logic        eo, et;
    @(negedge clk);
    op_a = a; op_b = b; imm = i; use_imm = u; opcode = op;
    bb = eff_b(b, i, u);
    er = exp_res(a, bb, op);
    eo = exp_ovf(a, bb, op);
    et = eo && (op == 4'd0 || op == 4'd2);  // R5
    @(posedge clk);
    #1;
    n_vec++;
    if (result !== er || ovf_flag !== eo || ovf_trap !== et) begin
      n_fail++;
      $display("FAIL %s (R2/R5) op=%0d a=%h b=%h: got res=%h ovf=%b trap=%b, exp res=%h ovf=%b trap=%b",
               tag(op, u), op, a, bb, result, ovf_flag, ovf_trap, er, eo, et);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] op_r;
    // R1: reset state
    @(negedge clk);
    op_a = 32'h7fffffff; op_b = 32'h1; opcode = 4'd0; rst = 1'b1;
    @(posedge clk); #1;
    n_vec++;
    if (result !== 32'd0 || ovf_flag !== 1'b0 || ovf_trap !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got res=%h ovf=%b trap=%b, exp 0 0 0", result, ovf_flag, ovf_trap);
    end
    @(negedge clk); rst = 1'b0;

    // Directed corners
    apply(32'h7fffffff, 32'h00000001, 16'h0, 1'b0, 4'd0);  // R3 pos+pos overflow, trap
    apply(32'h80000000, 32'hffffffff, 16'h0, 1'b0, 4'd0);  // R3 neg+neg overflow
    apply(32'h7fffffff, 32'h80000000, 16'h0, 1'b0, 4'd0);  // R3 mixed, no overflow
    apply(32'h7fffffff, 32'h00000001, 16'h0, 1'b0, 4'd1);  // R6 flag, no trap
    apply(32'h80000000, 32'h00000001, 16'h0, 1'b0, 4'd2);  // R4 neg-pos overflow
    apply(32'h7fffffff, 32'hffffffff, 16'h0, 1'b0, 4'd2);  // R4 pos-neg overflow
    apply(32'h80000000, 32'h80000000, 16'h0, 1'b0, 4'd2);  // R4 same sign
    apply(32'h80000000, 32'h00000001, 16'h0, 1'b0, 4'd3);  // R6 subu
    apply(32'h00000000, 32'h80000000, 16'h0, 1'b0, 4'd2);  // R4 A=0 can overflow
    apply(32'h00000005, 32'h0, 16'h8000, 1'b1, 4'd1);      // R7 unsigned imm sign-extends
    apply(32'h7fffffff, 32'h0, 16'h0001, 1'b1, 4'd0);      // R7 imm overflow trap
    apply(32'h80000000, 32'h00000001, 16'h0, 1'b0, 4'd4);  // R8 overflowing compare
    apply(32'h7fffffff, 32'hffffffff, 16'h0, 1'b0, 4'd4);  // R8
    apply(32'h7fffffff, 32'hffffffff, 16'h0, 1'b0, 4'd5);  // R9
    apply(32'h00000003, 32'h00000003, 16'h0, 1'b0, 4'd5);  // R9 equal
    apply(32'hffffffff, 32'h0, 16'hffff, 1'b1, 4'd5);      // R9 with imm
    apply(32'h7fffffff, 32'h00000001, 16'h0, 1'b0, 4'd9);  // R10 unused
    apply(32'hffffffff, 32'hffffffff, 16'h0, 1'b0, 4'd15); // R10 unused

    // Constrained random (R2..R10)
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (($urandom() % 4) == 0) ra = {ra[31], {31{ra[31] ? 1'b0 : 1'b1}}};
      op_r = ($urandom() % 8 == 0) ? 4'($urandom()) : 4'($urandom() % 6);
      apply(ra, rb, 16'($urandom()), 1'($urandom()), op_r);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule